// File: doc/BRIEF.md
# SPI FIFO status and interrupt unit

This unit sits between the host register port of an SPI controller and its shift engine. It holds a transmit FIFO that the host fills and the engine drains, and a receive FIFO that the engine fills and the host drains. From the fill levels of the two FIFOs it derives a status word, a five-bit interrupt vector with a mask and one combined interrupt line, and two DMA request lines.

The host reaches the unit through a single-cycle write/read strobe pair with a 4-bit address. Writing address 1 pushes a transmit word. Reading address 2 pops a receive word, and the word comes back combinationally in the same cycle. The other addresses hold the enable bit, the thresholds, the mask, the clear strobe and the DMA controls. The engine uses a pop strobe that sees the transmit head word and a push strobe that delivers a receive word. Levels, status, the interrupt vectors and the DMA requests come out as plain ports.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Each FIFO holds DEPTH words (32 by default, 64 as the alternative) and returns them in first-in first-out order. A host write to address 1 pushes a transmit word, and an engine pop removes the head shown on eng_tx_word. An engine push adds a receive word. A host read of address 2 pops the receive head and returns it on reg_rdata in the same cycle. tx_level and rx_level give the entry counts from the cycle after the edge that changed them.
- R2: The status bits are: bit 0 busy (unit enabled and engine busy), bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full. After reset the status reads 5'b01100.
- R3: A host write to a full transmit FIFO is dropped, and it sets the sticky transmit overflow flag, raw interrupt bit 1.
- R4: A host read of an empty receive FIFO returns zero and sets the sticky receive underflow flag, raw bit 2. An engine push into a full receive FIFO is dropped and sets the sticky receive overflow flag, raw bit 3.
- R5: A write to address 6 clears sticky flags. Data bit 0 clears all of them, bit 1 clears receive underflow, bit 2 clears receive overflow, bit 3 clears transmit overflow. An event in the same cycle as its clear leaves the flag set.
- R6: While the unit is enabled, raw bit 0 is high when the transmit level is at or below the transmit threshold (address 3). Raw bit 4 is high when the receive level is strictly above the receive threshold (address 4), so it first fires at threshold+1 entries. Both bits are low while the unit is disabled.
- R7: Address 0 bit 0 is the enable. Writing 0 empties both FIFOs by the next cycle. While the unit is disabled, host and engine pushes and pops are ignored and raise no flag.
- R8: The two thresholds and the two DMA levels (address 8 transmit, address 9 receive) take a write only while the unit is disabled. A write while the unit is enabled is ignored.
- R9: masked_int is raw_int ANDed with the mask at address 5, and irq is the OR of masked_int.
- R10: Address 7 bit 0 enables receive DMA requests and bit 1 enables transmit DMA requests. While the unit is enabled, tx_dma_req is high when the transmit level is at or below the transmit DMA level. rx_dma_req is high when the receive level is at least the receive DMA level plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | DATA_W | Host write data |
| reg_rdata | output | DATA_W | Receive head word on a read of address 2, else zero |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_word | output | DATA_W | Transmit head word |
| eng_rx_push | input | 1 | Engine delivers a receive word |
| eng_rx_word | input | DATA_W | Receive word from the engine |
| eng_busy | input | 1 | Engine is shifting |
| tx_level | output | clog2(DEPTH)+1 | Transmit entry count |
| rx_level | output | clog2(DEPTH)+1 | Receive entry count |
| status | output | 5 | Status word |
| raw_int | output | 5 | Unmasked interrupt vector |
| masked_int | output | 5 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Levels, sticky flags, level interrupts, masked bits, irq and DMA requests are all due in the cycle after the edge that captures a stimulus. The receive read data and the busy status bit follow the inputs within the same cycle. The bench drives inputs just after a falling edge and checks read data a moment later, before the next rising edge. The behavioural model steps on the same rising edge as the design, and every registered output is compared against it at the next falling edge. Targeted checks for overflow, underflow, clear priority, flush and locked thresholds are placed one idle cycle after the stimulus so that the capturing edge has passed.

// File: rtl/spfi_pkg.sv
package spfi_pkg;
   localparam int ADDR_W = 4;
   localparam int ST_W   = 5;
   localparam int IRQ_W  = 5;

   localparam logic [ADDR_W-1:0] ADR_ENABLE = 4'd0;
   localparam logic [ADDR_W-1:0] ADR_TXDATA = 4'd1;
   localparam logic [ADDR_W-1:0] ADR_RXDATA = 4'd2;
   localparam logic [ADDR_W-1:0] ADR_TXTHR  = 4'd3;
   localparam logic [ADDR_W-1:0] ADR_RXTHR  = 4'd4;
   localparam logic [ADDR_W-1:0] ADR_IMASK  = 4'd5;
   localparam logic [ADDR_W-1:0] ADR_ICLR   = 4'd6;
   localparam logic [ADDR_W-1:0] ADR_DMACTL = 4'd7;
   localparam logic [ADDR_W-1:0] ADR_TXDLVL = 4'd8;
   localparam logic [ADDR_W-1:0] ADR_RXDLVL = 4'd9;

   localparam int ST_BUSY   = 0;
   localparam int ST_TXFULL = 1;
   localparam int ST_TXEMPT = 2;
   localparam int ST_RXEMPT = 3;
   localparam int ST_RXFULL = 4;

   localparam int IRQ_TXEMPT = 0;
   localparam int IRQ_TXOVF  = 1;
   localparam int IRQ_RXUDF  = 2;
   localparam int IRQ_RXOVF  = 3;
   localparam int IRQ_RXTHR  = 4;

   localparam int CLR_ALL   = 0;
   localparam int CLR_RXUDF = 1;
   localparam int CLR_RXOVF = 2;
   localparam int CLR_TXOVF = 3;

   localparam int DMA_RX = 0;
   localparam int DMA_TX = 1;
endpackage

// File: rtl/spfi_fifo.sv
module spfi_fifo #(
   parameter int DEPTH = 32,
   parameter int DW    = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic                       pop,
   input  logic [DW-1:0]              din,
   output logic [DW-1:0]              dout,
   output logic [$clog2(DEPTH):0]     level,
   output logic                       full,
   output logic                       empty
);
   localparam int PW = $clog2(DEPTH);
   localparam int LW = PW + 1;

   if ((1 << PW) != DEPTH) begin : g_depth_not_pow2
      $error("spfi_fifo: DEPTH must be a power of two");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [LW-1:0] cnt;
   logic          push_ok, pop_ok;

   assign full    = (cnt == LW'(DEPTH));
   assign empty   = (cnt == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign level   = cnt;
   assign dout    = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         cnt <= cnt + LW'(push_ok) - LW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wr_ptr] <= din;
   end
endmodule

// File: rtl/spfi_irq.sv
module spfi_irq
   import spfi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_txovf,
   input  logic             ev_rxudf,
   input  logic             ev_rxovf,
   input  logic             clr_wr,
   input  logic [3:0]       clr_bits,
   input  logic             lvl_txempt,
   input  logic             lvl_rxthr,
   input  logic [IRQ_W-1:0] mask,
   output logic [IRQ_W-1:0] raw,
   output logic [IRQ_W-1:0] masked,
   output logic             irq
);
   logic txovf_q, rxudf_q, rxovf_q;
   logic clr_all, clr_txovf, clr_rxudf, clr_rxovf;

   assign clr_all   = clr_wr & clr_bits[CLR_ALL];
   assign clr_txovf = clr_all | (clr_wr & clr_bits[CLR_TXOVF]);
   assign clr_rxudf = clr_all | (clr_wr & clr_bits[CLR_RXUDF]);
   assign clr_rxovf = clr_all | (clr_wr & clr_bits[CLR_RXOVF]);

   // a new event outranks a clear arriving in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         txovf_q <= 1'b0;
         rxudf_q <= 1'b0;
         rxovf_q <= 1'b0;
      end else begin
         txovf_q <= ev_txovf | (txovf_q & ~clr_txovf);
         rxudf_q <= ev_rxudf | (rxudf_q & ~clr_rxudf);
         rxovf_q <= ev_rxovf | (rxovf_q & ~clr_rxovf);
      end
   end

   always_comb begin
      raw             = '0;
      raw[IRQ_TXEMPT] = lvl_txempt;
      raw[IRQ_TXOVF]  = txovf_q;
      raw[IRQ_RXUDF]  = rxudf_q;
      raw[IRQ_RXOVF]  = rxovf_q;
      raw[IRQ_RXTHR]  = lvl_rxthr;
   end

   for (genvar i = 0; i < IRQ_W; i++) begin : g_mask
      assign masked[i] = raw[i] & mask[i];
   end

   assign irq = |masked;
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
   import spfi_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic                    reg_rd,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [DATA_W-1:0]       reg_wdata,
   output logic [DATA_W-1:0]       reg_rdata,
   input  logic                    eng_tx_pop,
   output logic [DATA_W-1:0]       eng_tx_word,
   input  logic                    eng_rx_push,
   input  logic [DATA_W-1:0]       eng_rx_word,
   input  logic                    eng_busy,
   output logic [$clog2(DEPTH):0]  tx_level,
   output logic [$clog2(DEPTH):0]  rx_level,
   output logic [ST_W-1:0]         status,
   output logic [IRQ_W-1:0]        raw_int,
   output logic [IRQ_W-1:0]        masked_int,
   output logic                    irq,
   output logic                    tx_dma_req,
   output logic                    rx_dma_req
);
   localparam int PW = $clog2(DEPTH);
   localparam int LW = PW + 1;

   if (!(DEPTH == 32 || DEPTH == 64)) begin : g_bad_depth
      $error("spi_fifo_irq_unit: DEPTH must be 32 or 64");
   end
   if (DATA_W < PW || DATA_W < IRQ_W) begin : g_bad_width
      $error("spi_fifo_irq_unit: DATA_W too narrow for the control fields");
   end

   // configuration state
   logic          en_q;
   logic [PW-1:0] tx_thr_q, rx_thr_q, txd_lvl_q, rxd_lvl_q;
   logic [IRQ_W-1:0] mask_q;
   logic [1:0]    dmactl_q;

   logic wr_en, wr_txd, wr_clr, rd_rxd;
   logic en_d, flush;

   assign wr_en  = reg_wr && (reg_addr == ADR_ENABLE);
   assign wr_txd = reg_wr && (reg_addr == ADR_TXDATA);
   assign wr_clr = reg_wr && (reg_addr == ADR_ICLR);
   assign rd_rxd = reg_rd && (reg_addr == ADR_RXDATA);
   assign en_d   = wr_en ? reg_wdata[0] : en_q;
   assign flush  = ~en_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         tx_thr_q  <= '0;
         rx_thr_q  <= '0;
         txd_lvl_q <= '0;
         rxd_lvl_q <= '0;
         mask_q    <= '0;
         dmactl_q  <= '0;
      end else begin
         en_q <= en_d;
         if (reg_wr && reg_addr == ADR_IMASK)  mask_q   <= reg_wdata[IRQ_W-1:0];
         if (reg_wr && reg_addr == ADR_DMACTL) dmactl_q <= reg_wdata[1:0];
         if (reg_wr && !en_q) begin
            if (reg_addr == ADR_TXTHR)  tx_thr_q  <= reg_wdata[PW-1:0];
            if (reg_addr == ADR_RXTHR)  rx_thr_q  <= reg_wdata[PW-1:0];
            if (reg_addr == ADR_TXDLVL) txd_lvl_q <= reg_wdata[PW-1:0];
            if (reg_addr == ADR_RXDLVL) rxd_lvl_q <= reg_wdata[PW-1:0];
         end
      end
   end

   // FIFOs
   logic tx_full, tx_empty, rx_full, rx_empty;
   logic tx_push, tx_pop, rx_push, rx_pop;
   logic [DATA_W-1:0] rx_head;

   assign tx_push = en_q & wr_txd;
   assign tx_pop  = en_q & eng_tx_pop;
   assign rx_push = en_q & eng_rx_push;
   assign rx_pop  = en_q & rd_rxd;

   spfi_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (tx_push),
      .pop   (tx_pop),
      .din   (reg_wdata),
      .dout  (eng_tx_word),
      .level (tx_level),
      .full  (tx_full),
      .empty (tx_empty)
   );

   spfi_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (rx_push),
      .pop   (rx_pop),
      .din   (eng_rx_word),
      .dout  (rx_head),
      .level (rx_level),
      .full  (rx_full),
      .empty (rx_empty)
   );

   assign reg_rdata = (rx_pop && !rx_empty) ? rx_head : '0;

   // status word
   always_comb begin
      status            = '0;
      status[ST_BUSY]   = en_q & eng_busy;
      status[ST_TXFULL] = tx_full;
      status[ST_TXEMPT] = tx_empty;
      status[ST_RXEMPT] = rx_empty;
      status[ST_RXFULL] = rx_full;
   end

   // interrupts
   logic lvl_txempt, lvl_rxthr;
   assign lvl_txempt = en_q & (tx_level <= {1'b0, tx_thr_q});
   assign lvl_rxthr  = en_q & (rx_level >  {1'b0, rx_thr_q});

   spfi_irq u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_txovf   (tx_push & tx_full),
      .ev_rxudf   (rx_pop & rx_empty),
      .ev_rxovf   (rx_push & rx_full),
      .clr_wr     (wr_clr),
      .clr_bits   (reg_wdata[3:0]),
      .lvl_txempt (lvl_txempt),
      .lvl_rxthr  (lvl_rxthr),
      .mask       (mask_q),
      .raw        (raw_int),
      .masked     (masked_int),
      .irq        (irq)
   );

   // DMA requests
   assign tx_dma_req = en_q & dmactl_q[DMA_TX] & (tx_level <= LW'(txd_lvl_q));
   assign rx_dma_req = en_q & dmactl_q[DMA_RX] & (rx_level >  LW'(rxd_lvl_q));
endmodule

// File: rtl/spfi_chk.sv
module spfi_chk
   import spfi_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int DATA_W = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   reg_wr,
   input logic                   reg_rd,
   input logic [ADDR_W-1:0]      reg_addr,
   input logic [DATA_W-1:0]      reg_wdata,
   input logic [$clog2(DEPTH):0] tx_level,
   input logic [$clog2(DEPTH):0] rx_level,
   input logic [IRQ_W-1:0]       raw_int,
   input logic [IRQ_W-1:0]       masked_int,
   input logic                   irq,
   input logic                   en_q,
   input logic [$clog2(DEPTH)-1:0] rx_thr_q
);
   localparam int LW = $clog2(DEPTH) + 1;

   assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

   assert_tx_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && reg_wr && reg_addr == ADR_TXDATA && tx_level == LW'(DEPTH))
      |=> raw_int[IRQ_TXOVF]);

   assert_rx_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && reg_rd && reg_addr == ADR_RXDATA && rx_level == '0)
      |=> raw_int[IRQ_RXUDF]);

   assert_clear_txovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_ICLR && reg_wdata[CLR_TXOVF])
      |=> !raw_int[IRQ_TXOVF]);

   assert_rx_threshold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      raw_int[IRQ_RXTHR] |-> (en_q && rx_level > {1'b0, rx_thr_q}));

   assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_ENABLE && !reg_wdata[0])
      |=> (tx_level == '0 && rx_level == '0));

   assert_mask_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((masked_int & ~raw_int) == '0) && ((masked_int == '0) -> !irq));
endmodule

bind spi_fifo_irq_unit spfi_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_spfi_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .tx_level   (tx_level),
   .rx_level   (rx_level),
   .raw_int    (raw_int),
   .masked_int (masked_int),
   .irq        (irq),
   .en_q       (en_q),
   .rx_thr_q   (rx_thr_q)
);

// File: tb/tb_spi_fifo_irq_unit.sv
`timescale 1ns/100ps
module tb_spi_fifo_irq_unit;
   import spfi_pkg::*;

   localparam int DEPTH = 32;
   localparam int DW    = 16;
   localparam int PW    = $clog2(DEPTH);
   localparam int LW    = PW + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              reg_wr = 0, reg_rd = 0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DW-1:0]     reg_wdata = '0;
   logic [DW-1:0]     reg_rdata;
   logic              eng_tx_pop = 0, eng_rx_push = 0, eng_busy = 0;
   logic [DW-1:0]     eng_tx_word, eng_rx_word = '0;
   logic [LW-1:0]     tx_level, rx_level;
   logic [ST_W-1:0]   status;
   logic [IRQ_W-1:0]  raw_int, masked_int;
   logic              irq, tx_dma_req, rx_dma_req;

   spi_fifo_irq_unit #(.DEPTH(DEPTH), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_tx_pop(eng_tx_pop), .eng_tx_word(eng_tx_word),
      .eng_rx_push(eng_rx_push), .eng_rx_word(eng_rx_word), .eng_busy(eng_busy),
      .tx_level(tx_level), .rx_level(rx_level), .status(status),
      .raw_int(raw_int), .masked_int(masked_int), .irq(irq),
      .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
   );

   // reference model state
   bit            m_en, m_tovf, m_udf, m_rovf, mon_on, done;
   int            m_txthr, m_rxthr, m_txdl, m_rxdl;
   logic [4:0]    m_mask;
   logic [1:0]    m_dma;
   logic [DW-1:0] tq[$];
   logic [DW-1:0] rq[$];
   int            n_chk = 0, n_bad = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin : model
      bit en_n, e_tovf, e_udf, e_rovf, tpush, tpop, rpush, rpop;
      if (!rst_n) begin
         m_en = 0; m_tovf = 0; m_udf = 0; m_rovf = 0;
         m_txthr = 0; m_rxthr = 0; m_txdl = 0; m_rxdl = 0;
         m_mask = '0; m_dma = '0;
         tq.delete(); rq.delete();
         mon_on = 1;
      end else begin
         en_n = m_en; e_tovf = 0; e_udf = 0; e_rovf = 0;
         tpush = 0; tpop = 0; rpush = 0; rpop = 0;
         if (reg_wr && reg_addr == ADR_ENABLE) en_n = reg_wdata[0];
         if (m_en && reg_wr && reg_addr == ADR_TXDATA) begin
            if (tq.size() == DEPTH) e_tovf = 1; else tpush = 1;
         end
         if (m_en && eng_tx_pop && tq.size() > 0) tpop = 1;
         if (m_en && reg_rd && reg_addr == ADR_RXDATA) begin
            if (rq.size() == 0) e_udf = 1; else rpop = 1;
         end
         if (m_en && eng_rx_push) begin
            if (rq.size() == DEPTH) e_rovf = 1; else rpush = 1;
         end
         if (tpop) void'(tq.pop_front());
         if (tpush) tq.push_back(reg_wdata);
         if (rpop) void'(rq.pop_front());
         if (rpush) rq.push_back(eng_rx_word);
         if (!en_n) begin tq.delete(); rq.delete(); end
         if (reg_wr && reg_addr == ADR_ICLR) begin
            if (reg_wdata[0]) begin m_tovf = 0; m_udf = 0; m_rovf = 0; end
            if (reg_wdata[1]) m_udf = 0;
            if (reg_wdata[2]) m_rovf = 0;
            if (reg_wdata[3]) m_tovf = 0;
         end
         if (e_tovf) m_tovf = 1;
         if (e_udf)  m_udf = 1;
         if (e_rovf) m_rovf = 1;
         if (reg_wr && reg_addr == ADR_IMASK)  m_mask = reg_wdata[4:0];
         if (reg_wr && reg_addr == ADR_DMACTL) m_dma = reg_wdata[1:0];
         if (reg_wr && !m_en) begin
            if (reg_addr == ADR_TXTHR)  m_txthr = int'(reg_wdata[PW-1:0]);
            if (reg_addr == ADR_RXTHR)  m_rxthr = int'(reg_wdata[PW-1:0]);
            if (reg_addr == ADR_TXDLVL) m_txdl  = int'(reg_wdata[PW-1:0]);
            if (reg_addr == ADR_RXDLVL) m_rxdl  = int'(reg_wdata[PW-1:0]);
         end
         m_en = en_n;
      end
   end

   function automatic logic [4:0] e_raw();
      logic [4:0] r;
      r[0] = m_en && (tq.size() <= m_txthr);
      r[1] = m_tovf;
      r[2] = m_udf;
      r[3] = m_rovf;
      r[4] = m_en && (rq.size() > m_rxthr);
      return r;
   endfunction

   // compare on every falling edge
   always @(negedge clk) begin
      if (mon_on && !done) begin
         logic [4:0] er;
         er = e_raw();
         chk("R1", "tx_level", 32'(tx_level), tq.size());
         chk("R1", "rx_level", 32'(rx_level), rq.size());
         if (tq.size() > 0) chk("R1", "tx_head", 32'(eng_tx_word), 32'(tq[0]));
         chk("R2", "status_busy", 32'(status[0]), 32'(m_en && eng_busy));
         chk("R2", "status_txfull", 32'(status[1]), 32'(tq.size() == DEPTH));
         chk("R2", "status_txempty", 32'(status[2]), 32'(tq.size() == 0));
         chk("R2", "status_rxempty", 32'(status[3]), 32'(rq.size() == 0));
         chk("R2", "status_rxfull", 32'(status[4]), 32'(rq.size() == DEPTH));
         chk("R6", "raw_txempty", 32'(raw_int[0]), 32'(er[0]));
         chk("R3", "raw_txovf", 32'(raw_int[1]), 32'(er[1]));
         chk("R4", "raw_rxudf", 32'(raw_int[2]), 32'(er[2]));
         chk("R4", "raw_rxovf", 32'(raw_int[3]), 32'(er[3]));
         chk("R6", "raw_rxthr", 32'(raw_int[4]), 32'(er[4]));
         chk("R9", "masked_int", 32'(masked_int), 32'(er & m_mask));
         chk("R9", "irq", 32'(irq), 32'(|(er & m_mask)));
         chk("R10", "tx_dma_req", 32'(tx_dma_req),
             32'(m_en && m_dma[1] && tq.size() <= m_txdl));
         chk("R10", "rx_dma_req", 32'(rx_dma_req),
             32'(m_en && m_dma[0] && rq.size() >= m_rxdl + 1));
      end
   end

   task automatic cyc(input logic wr, input logic rd, input logic [3:0] a,
                      input logic [DW-1:0] d, input logic tp, input logic rp,
                      input logic [DW-1:0] rw, input logic bz);
      logic [DW-1:0] exp;
      @(negedge clk); #1;
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
      eng_tx_pop = tp; eng_rx_push = rp; eng_rx_word = rw; eng_busy = bz;
      if (rd && a == ADR_RXDATA) begin
         exp = (m_en && rq.size() > 0) ? rq[0] : '0;
         #0.5;
         if (m_en && rq.size() == 0) chk("R4", "rdata_on_empty", 32'(reg_rdata), 32'(exp));
         else                        chk("R1", "rdata", 32'(reg_rdata), 32'(exp));
      end
   endtask

   task automatic idle();              cyc(0, 0, 4'd0, '0, 0, 0, '0, 0); endtask
   task automatic wreg(input logic [3:0] a, input logic [DW-1:0] d); cyc(1, 0, a, d, 0, 0, '0, 0); endtask
   task automatic rread();             cyc(0, 1, ADR_RXDATA, '0, 0, 0, '0, 0); endtask
   task automatic epush(input logic [DW-1:0] w); cyc(0, 0, 4'd0, '0, 0, 1, w, 0); endtask
   task automatic epop();              cyc(0, 0, 4'd0, '0, 1, 0, '0, 1); endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      idle();
      chk("R2", "reset_status", 32'(status), 32'h0C);
      chk("R9", "reset_irq", 32'(irq), 0);

      // program while disabled, then enable
      wreg(ADR_TXTHR, 2); wreg(ADR_RXTHR, 3);
      wreg(ADR_TXDLVL, 4); wreg(ADR_RXDLVL, 1);
      wreg(ADR_IMASK, 16'h1F); wreg(ADR_DMACTL, 3);
      wreg(ADR_ENABLE, 1);

      for (int i = 0; i < 5; i++) wreg(ADR_TXDATA, 16'hA000 + 16'(i));
      epop(); epop();
      for (int i = 0; i < 3; i++) epush(16'hB000 + 16'(i));
      idle();
      chk("R1", "tx_after_pops", 32'(tx_level), 3);
      chk("R1", "tx_head_order", 32'(eng_tx_word), 32'hA002);
      chk("R6", "rx_at_thr_no_int", 32'(raw_int[4]), 0);
      epush(16'hB003);
      idle();
      chk("R6", "rx_above_thr_int", 32'(raw_int[4]), 1);
      for (int i = 0; i < 2; i++) rread();

      // transmit overflow
      for (int i = 0; i < DEPTH; i++) wreg(ADR_TXDATA, 16'hC000 + 16'(i));
      idle();
      chk("R3", "tx_full_level", 32'(tx_level), DEPTH);
      chk("R3", "tx_ovf_flag", 32'(raw_int[1]), 1);
      chk("R10", "tx_dma_off_when_full", 32'(tx_dma_req), 0);

      // receive overflow and set-over-clear
      for (int i = 0; i < DEPTH + 1; i++) epush(16'hD000 + 16'(i));
      idle();
      chk("R4", "rx_ovf_flag", 32'(raw_int[3]), 1);
      cyc(1, 0, ADR_ICLR, 16'h4, 0, 1, 16'hEEEE, 0);
      idle();
      chk("R5", "ovf_set_wins", 32'(raw_int[3]), 1);
      wreg(ADR_ICLR, 16'h4);
      idle();
      chk("R5", "rxovf_cleared", 32'(raw_int[3]), 0);
      chk("R5", "txovf_kept", 32'(raw_int[1]), 1);

      // drain and underflow
      for (int i = 0; i < DEPTH + 1; i++) rread();
      idle();
      chk("R4", "rx_udf_flag", 32'(raw_int[2]), 1);
      wreg(ADR_ICLR, 16'h2);
      idle();
      chk("R5", "udf_cleared", 32'(raw_int[2]), 0);
      wreg(ADR_ICLR, 16'h8);
      idle();
      chk("R5", "txovf_cleared", 32'(raw_int[1]), 0);

      // threshold locked while enabled
      wreg(ADR_RXTHR, 0);
      epush(16'h1234);
      idle();
      chk("R8", "rxthr_write_ignored", 32'(raw_int[4]), 0);

      // masking
      wreg(ADR_IMASK, 16'h0);
      idle();
      chk("R9", "all_masked_irq", 32'(irq), 0);
      wreg(ADR_IMASK, 16'h02);
      idle();
      chk("R9", "only_txovf_masked", 32'(masked_int), 0);
      wreg(ADR_DMACTL, 0);
      idle();
      chk("R10", "dma_disabled", 32'({tx_dma_req, rx_dma_req}), 0);
      wreg(ADR_DMACTL, 3); wreg(ADR_IMASK, 16'h1F);

      // disable flushes, disabled pushes ignored
      wreg(ADR_ENABLE, 0);
      idle();
      chk("R7", "flush_tx", 32'(tx_level), 0);
      chk("R7", "flush_rx", 32'(rx_level), 0);
      wreg(ADR_TXDATA, 16'h5555);
      epush(16'h6666);
      idle();
      chk("R7", "disabled_push_ignored", 32'({tx_level, rx_level}), 0);
      chk("R7", "disabled_no_flag", 32'(raw_int), 0);
      wreg(ADR_RXTHR, 0);
      wreg(ADR_ENABLE, 1);
      epush(16'h7777);
      idle();
      chk("R8", "rxthr_write_taken_disabled", 32'(raw_int[4]), 1);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int r;
         logic [3:0] a;
         logic [DW-1:0] d;
         r = int'($urandom_range(0, 99));
         d = DW'($urandom);
         a = 4'($urandom_range(0, 9));
         if (a == ADR_ENABLE) d[0] = ($urandom_range(0, 15) != 0);
         if (a == ADR_TXDATA || a == ADR_RXDATA) a = ADR_ICLR;
         if (r < 35)
            cyc(1, 0, ADR_TXDATA, d, 1'($urandom), 1'($urandom), DW'($urandom), 1'($urandom));
         else if (r < 65)
            cyc(0, 1, ADR_RXDATA, '0, 1'($urandom), 1'($urandom), DW'($urandom), 1'($urandom));
         else if (r < 80)
            cyc(1, 0, a, d, 1'($urandom), 1'($urandom), DW'($urandom), 1'($urandom));
         else
            cyc(0, 0, 4'd0, '0, 1'($urandom), 1'($urandom), DW'($urandom), 1'($urandom));
      end
      idle();
      idle();

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule